// File: doc/BRIEF.md
# Monitor Capture Event Trigger

This block decides the moment from which monitored bus traffic is handed to the host. It holds a single sticky capture flag. The flag is written into the header of every message that follows. A configuration write arms the block. That write latches the event settings and clears the flag. From then on the block watches for one chosen kind of event:

- immediate capture, with no condition;
- a decoded command word that matches a 16-bit value under a 16-bit mask;
- any enabled exception bit of a message that has just finished;
- a rising edge on one of four external monitor input pins.

The pin is picked by configuration.

When the armed event occurs, the flag goes high. It stays high until the next arming write. The flag does not depend on bus decoding or on the transfer engine. Both are neighbours that feed or consume this block.

Top module: `mon_capture_trigger`

## Requirements
- R1: After reset `capture_o` is 0 and the block is unarmed. While unarmed, no command, exception or pin activity sets `capture_o`.
- R2: The arming write latches the configuration and marks the block armed. It is a cycle with `arm_i` high, sampled on a rising clock edge. `capture_o` is 0 after that edge. The event kind `ev_kind_i` is encoded 0 = immediate, 1 = command template, 2 = exception, 3 = external pin.
- R3: In immediate mode, `capture_o` is 0 after the arming edge and 1 after the next rising edge.
- R4: In template mode, a command word presented with `cmd_valid_i` high matches when `((cmd_word_i ^ value) & mask) == 0`. A mask bit of 1 means that bit is compared. On a match, `capture_o` is 1 after that edge.
- R5: In template mode, a command word with a compared bit that differs has no effect on `capture_o`. A command word presented while `cmd_valid_i` is low also has no effect.
- R6: In exception mode, `capture_o` is set after an edge where `msg_end_i` is high and `exc_vec_i & exc_en_i` is nonzero. The bits of `exc_vec_i` are:
  - bit 0: invalid command;
  - bit 1: invalid data;
  - bit 2: invalid status;
  - bit 3: gap before data;
  - bit 4: response timeout;
  - bit 5: wrong RT address;
  - bit 6: status set condition;
  - bit 7: illegal command.

  Disabled bits are ignored. An exception vector without `msg_end_i` is also ignored.
- R7: In pin mode, `mon_pin_i[pin_sel_i]` passes through a two-flop synchronizer and is detected on its rising edge. A pin that rises just before clock edge N sets `capture_o` after edge N+2. The following have no effect:
  - activity on the other pins;
  - a pin that is already high when the block is armed.
- R8: Once set, `capture_o` stays 1 until the next arming write. An arming write takes priority over an event in the same cycle.
- R9: Changes on the configuration inputs without an arming write have no effect on the active event settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Configuration write: latch settings, clear flag, arm |
| ev_kind_i | input | 2 | Event kind (0 immediate, 1 template, 2 exception, 3 pin) |
| tmpl_val_i | input | 16 | Command template value |
| tmpl_mask_i | input | 16 | Command template mask, 1 = compare bit |
| exc_en_i | input | 8 | Exception enable mask |
| pin_sel_i | input | 2 | External trigger pin number |
| cmd_valid_i | input | 1 | Decoded command word valid |
| cmd_word_i | input | 16 | Decoded command word |
| msg_end_i | input | 1 | Message end strobe for the exception vector |
| exc_vec_i | input | 8 | Per-message exception flags |
| mon_pin_i | input | 4 | Asynchronous external monitor input pins |
| capture_o | output | 1 | Sticky capture flag |

## Verification
A wrong armed state or stale latched settings show up as a flag that rises when it should not, or one that fails to rise. This is visible at `capture_o` one edge after the event that should, or should not, have set it. A synchronizer with the wrong depth shifts the pin-mode rise by a whole cycle, so `capture_o` is sampled exactly two edges after the pin change. A flag that is not sticky, or not cleared by arming, appears in the first cycle after the event or after the arming write.

// File: rtl/mon_cap_pkg.sv
package mon_cap_pkg;
  localparam int CMD_W     = 16;
  localparam int EXC_W     = 8;
  localparam int PIN_N     = 4;
  localparam int PIN_SEL_W = $clog2(PIN_N);
  localparam int SYNC_N    = 2;

  typedef enum logic [1:0] {
    EV_IMMEDIATE = 2'd0,
    EV_TEMPLATE  = 2'd1,
    EV_EXCEPTION = 2'd2,
    EV_PIN       = 2'd3
  } ev_kind_e;

  typedef struct packed {
    ev_kind_e               kind;
    logic [CMD_W-1:0]       tval;
    logic [CMD_W-1:0]       tmask;
    logic [EXC_W-1:0]       exc_en;
    logic [PIN_SEL_W-1:0]   pin_sel;
  } cap_cfg_t;
endpackage

// File: rtl/mon_cap_cfg.sv
module mon_cap_cfg
  import mon_cap_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     arm_i,
  input  cap_cfg_t cfg_i,
  output cap_cfg_t cfg_o,
  output logic     armed_o
);
  cap_cfg_t cfg_q;
  logic     armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
    end else if (arm_i) begin
      cfg_q   <= cfg_i;
      armed_q <= 1'b1;
    end
  end

  assign cfg_o   = cfg_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/mon_cap_pin_sync.sv
module mon_cap_pin_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  localparam int LAST = STAGES;

  for (genvar g = 0; g < N; g++) begin : g_pin
    // stages 0..STAGES-1 synchronize, stage STAGES holds previous value
    logic [LAST:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[LAST-1:0], pin_i[g]};
    end
    assign rise_o[g] = sh_q[LAST-1] & ~sh_q[LAST];
  end
endmodule

// File: rtl/mon_cap_detect.sv
module mon_cap_detect
  import mon_cap_pkg::*;
(
  input  cap_cfg_t          cfg_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic              msg_end_i,
  input  logic [EXC_W-1:0]  exc_vec_i,
  input  logic [PIN_N-1:0]  pin_rise_i,
  output logic              hit_o
);
  logic tmpl_hit, exc_hit, pin_hit;

  assign tmpl_hit = cmd_valid_i && (((cmd_word_i ^ cfg_i.tval) & cfg_i.tmask) == '0);
  assign exc_hit  = msg_end_i && |(exc_vec_i & cfg_i.exc_en);
  assign pin_hit  = pin_rise_i[cfg_i.pin_sel];

  always_comb begin
    unique case (cfg_i.kind)
      EV_IMMEDIATE: hit_o = 1'b1;
      EV_TEMPLATE:  hit_o = tmpl_hit;
      EV_EXCEPTION: hit_o = exc_hit;
      EV_PIN:       hit_o = pin_hit;
      default:      hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mon_capture_trigger.sv
module mon_capture_trigger
  import mon_cap_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 arm_i,
  input  logic [1:0]           ev_kind_i,
  input  logic [CMD_W-1:0]     tmpl_val_i,
  input  logic [CMD_W-1:0]     tmpl_mask_i,
  input  logic [EXC_W-1:0]     exc_en_i,
  input  logic [PIN_SEL_W-1:0] pin_sel_i,
  input  logic                 cmd_valid_i,
  input  logic [CMD_W-1:0]     cmd_word_i,
  input  logic                 msg_end_i,
  input  logic [EXC_W-1:0]     exc_vec_i,
  input  logic [PIN_N-1:0]     mon_pin_i,
  output logic                 capture_o
);
  cap_cfg_t         cfg_in, cfg_w;
  logic             armed_w;
  logic [PIN_N-1:0] pin_rise;
  logic             hit;
  logic             cap_q;

  always_comb begin
    cfg_in.kind    = ev_kind_e'(ev_kind_i);
    cfg_in.tval    = tmpl_val_i;
    cfg_in.tmask   = tmpl_mask_i;
    cfg_in.exc_en  = exc_en_i;
    cfg_in.pin_sel = pin_sel_i;
  end

  mon_cap_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .cfg_i   (cfg_in),
    .cfg_o   (cfg_w),
    .armed_o (armed_w)
  );

  mon_cap_pin_sync #(.N(PIN_N), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (mon_pin_i),
    .rise_o (pin_rise)
  );

  mon_cap_detect u_det (
    .cfg_i       (cfg_w),
    .cmd_valid_i (cmd_valid_i),
    .cmd_word_i  (cmd_word_i),
    .msg_end_i   (msg_end_i),
    .exc_vec_i   (exc_vec_i),
    .pin_rise_i  (pin_rise),
    .hit_o       (hit)
  );

  // arming wins over a same-cycle event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cap_q <= 1'b0;
    else if (arm_i)           cap_q <= 1'b0;
    else if (armed_w && hit)  cap_q <= 1'b1;
  end

  assign capture_o = cap_q;
endmodule

// File: rtl/mon_cap_chk.sv
module mon_cap_chk
  import mon_cap_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             armed,
  input cap_cfg_t         cfg,
  input logic             cmd_valid_i,
  input logic [CMD_W-1:0] cmd_word_i,
  input logic             msg_end_i,
  input logic [EXC_W-1:0] exc_vec_i,
  input logic             capture_o
);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !arm_i && !capture_o) |=> !capture_o);

  p_arm_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !capture_o);

  p_immediate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !arm_i && cfg.kind == EV_IMMEDIATE) |=> capture_o);

  p_template_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !arm_i && cfg.kind == EV_TEMPLATE && cmd_valid_i &&
     (((cmd_word_i ^ cfg.tval) & cfg.tmask) == '0)) |=> capture_o);

  p_exception_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !arm_i && cfg.kind == EV_EXCEPTION && msg_end_i &&
     ((exc_vec_i & cfg.exc_en) != '0)) |=> capture_o);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && !arm_i) |=> capture_o);
endmodule

bind mon_capture_trigger mon_cap_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arm_i       (arm_i),
  .armed       (armed_w),
  .cfg         (cfg_w),
  .cmd_valid_i (cmd_valid_i),
  .cmd_word_i  (cmd_word_i),
  .msg_end_i   (msg_end_i),
  .exc_vec_i   (exc_vec_i),
  .capture_o   (capture_o)
);

// File: tb/sim_mon_capture_trigger.sv
`timescale 1ns/1ps
module sim_mon_capture_trigger;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0;
  logic [1:0]  ev_kind_i = '0;
  logic [15:0] tmpl_val_i = '0;
  logic [15:0] tmpl_mask_i = '0;
  logic [7:0]  exc_en_i = '0;
  logic [1:0]  pin_sel_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic [15:0] cmd_word_i = '0;
  logic        msg_end_i = 1'b0;
  logic [7:0]  exc_vec_i = '0;
  logic [3:0]  mon_pin_i = '0;
  logic        capture_o;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  mon_capture_trigger u0 (
    .clk_i(clk), .rst_ni(rst_ni), .arm_i(arm_i), .ev_kind_i(ev_kind_i),
    .tmpl_val_i(tmpl_val_i), .tmpl_mask_i(tmpl_mask_i), .exc_en_i(exc_en_i),
    .pin_sel_i(pin_sel_i), .cmd_valid_i(cmd_valid_i), .cmd_word_i(cmd_word_i),
    .msg_end_i(msg_end_i), .exc_vec_i(exc_vec_i), .mon_pin_i(mon_pin_i),
    .capture_o(capture_o)
  );

  // behavioural reference
  bit         m_cap, m_armed;
  int         m_kind, m_sel;
  bit [15:0]  m_val, m_mask;
  bit [7:0]   m_en;
  bit [3:0]   hist[$];

  initial hist = '{4'h0, 4'h0, 4'h0};

  always @(posedge clk) begin
    bit hit, rise;
    if (!rst_ni) begin
      m_cap = 0; m_armed = 0; m_kind = 0; m_sel = 0;
      m_val = 0; m_mask = 0; m_en = 0;
      hist = '{4'h0, 4'h0, 4'h0};
    end else begin
      rise = hist[1][m_sel] && !hist[2][m_sel];
      case (m_kind)
        0: hit = 1;
        1: hit = cmd_valid_i && ((cmd_word_i & m_mask) == (m_val & m_mask));
        2: hit = msg_end_i && ((exc_vec_i & m_en) != 0);
        default: hit = rise;
      endcase
      if (arm_i) begin
        m_cap = 0; m_armed = 1; m_kind = int'(ev_kind_i); m_sel = int'(pin_sel_i);
        m_val = tmpl_val_i; m_mask = tmpl_mask_i; m_en = exc_en_i;
      end else if (m_armed && hit) m_cap = 1;
      hist.push_front(mon_pin_i);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      checks++;
      if (capture_o !== m_cap) begin
        fails++;
        $display("FAIL %s model compare: got %0b exp %0b at %0t", cur_req, capture_o, m_cap, $time);
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, bit exp);
    checks++;
    if (capture_o !== exp) begin
      fails++;
      $display("FAIL %s: capture_o got %0b exp %0b at %0t", req, capture_o, exp, $time);
    end
  endtask

  task automatic arm(int kind, bit [15:0] v, bit [15:0] m, bit [7:0] en, int sel);
    ev_kind_i = 2'(kind); tmpl_val_i = v; tmpl_mask_i = m;
    exc_en_i = en; pin_sel_i = 2'(sel); arm_i = 1'b1;
    step();
    arm_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    step(3);
    chk("R1", 1'b0);
    rst_ni = 1'b1;
    step();
    chk("R1", 1'b0);
    // unarmed activity
    cmd_valid_i = 1; cmd_word_i = 16'h0000; msg_end_i = 1; exc_vec_i = 8'hFF; mon_pin_i = 4'hF;
    step(5);
    chk("R1", 1'b0);
    cmd_valid_i = 0; msg_end_i = 0; exc_vec_i = 0; mon_pin_i = 0;
    step(4);

    cur_req = "R3";
    arm(0, 0, 0, 0, 0);
    chk("R3", 1'b0);
    step();
    chk("R3", 1'b1);

    cur_req = "R4";
    arm(1, 16'hA5C0, 16'hFFF0, 0, 0);
    chk("R2", 1'b0);
    cmd_valid_i = 1; cmd_word_i = 16'hA5D3;
    step();
    chk("R5", 1'b0);
    cmd_valid_i = 0; cmd_word_i = 16'hA5C7;
    step();
    chk("R5", 1'b0);
    cmd_valid_i = 1;
    step();
    chk("R4", 1'b1);
    cmd_valid_i = 0;
    step(3);
    chk("R8", 1'b1);

    cur_req = "R9";
    arm(1, 16'h0000, 16'hFFFF, 0, 0);
    ev_kind_i = 2'd0; tmpl_mask_i = 16'h0000;
    step(3);
    chk("R9", 1'b0);
    cmd_valid_i = 1; cmd_word_i = 16'h1234;
    step();
    chk("R9", 1'b0);
    cmd_word_i = 16'h0000;
    step();
    chk("R4", 1'b1);
    cmd_valid_i = 0;

    cur_req = "R6";
    arm(2, 0, 0, 8'b0010_0100, 0);
    chk("R2", 1'b0);
    msg_end_i = 1; exc_vec_i = 8'b0000_0001;
    step();
    chk("R6", 1'b0);
    msg_end_i = 0; exc_vec_i = 8'b0010_0000;
    step();
    chk("R6", 1'b0);
    msg_end_i = 1; exc_vec_i = 8'b0000_0100;
    step();
    chk("R6", 1'b1);
    msg_end_i = 0; exc_vec_i = 0;

    cur_req = "R7";
    arm(3, 0, 0, 0, 2);
    mon_pin_i = 4'b0010;
    step(4);
    chk("R7", 1'b0);
    mon_pin_i = 4'b0110;
    step();
    chk("R7", 1'b0);
    step();
    chk("R7", 1'b0);
    step();
    chk("R7", 1'b1);
    arm(3, 0, 0, 0, 2);
    step(4);
    chk("R7", 1'b0);
    mon_pin_i = 4'b0000;
    step(3);
    mon_pin_i = 4'b0100;
    step(3);
    chk("R7", 1'b1);

    cur_req = "R8";
    step(3);
    chk("R8", 1'b1);
    cmd_valid_i = 1; cmd_word_i = 16'h5555;
    arm(1, 16'h0000, 16'h0000, 0, 0);
    chk("R8", 1'b0);
    step();
    chk("R4", 1'b1);
    cmd_valid_i = 0;
    arm(2, 0, 0, 8'h00, 0);
    chk("R2", 1'b0);
    msg_end_i = 1; exc_vec_i = 8'hFF;
    step(2);
    chk("R6", 1'b0);
    msg_end_i = 0; exc_vec_i = 0;
    step(2);
    finish_run();
  end
endmodule